// File: doc/BRIEF.md
# Narrow Operand Width Predictor and Channel Steerer

This block decides, for each integer result that crosses between execution clusters, whether the result travels on a narrow low-latency link or on the full-width base link. The decision has to be made at dispatch, because the consumer's wake-up tag goes out before the value exists. A table of two-bit saturating confidence counters is indexed by instruction address. At dispatch the table answers whether the result is expected to be narrow. The answer travels with the instruction and comes back at writeback.

At writeback the block inspects the real 64-bit value and trains the counter for that instruction address. It then emits the result as a packet on one of the two links, one cycle later. A narrow packet is 18 bits: an 8-bit register tag above 10 data bits. A wide packet is 72 bits: the tag above the full 64-bit value. When a result predicted narrow turns out wide, it goes out on the wide link and a one-cycle flag tells the consumer to replay its early wake-up. Branch-mispredict notices carry only a branch identifier and always use the narrow link. They have priority over a narrow result in the same cycle.

Top module: `opnd_width_steer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all outputs are low. Every confidence counter starts at 0, so every lookup answers "wide" until it has been trained.
- R2: A result counts as narrow exactly when its 64-bit value, read as unsigned, lies in 0..1023 and so fits in 10 bits. The value 1024 and anything above it are wide.
- R3: A lookup with `disp_vld` high produces `disp_rsp_vld` high in the next cycle. In that cycle `disp_rsp_nar` is 1 only if the addressed counter equals 3, its maximum. Values 0, 1 and 2 all answer wide.
- R4: The table holds 8192 counters, indexed by instruction-address bits [14:2]. Addresses that differ only in bits [1:0] or above bit 14 share a counter. Addresses that differ in bits [14:2] do not.
- R5: Every writeback trains its counter. A narrow value increments the counter and a wide value decrements it. The counter saturates at 3 and at 0. Training is visible to a lookup issued in the cycle after the writeback.
- R6: A writeback predicted narrow with a narrow value gives, one cycle later, `nar_vld`=1, `nar_is_br`=0 and `nar_pkt` = {tag in bits [17:10], value[9:0] in bits [9:0]}, with `wid_vld`=0 and `pred_miss`=0.
- R7: A writeback predicted narrow with a wide value gives, one cycle later, `wid_vld`=1 with the wide packet, `nar_vld`=0, and `pred_miss`=1 for exactly that one cycle.
- R8: A writeback predicted wide always goes on the wide link, whatever its value, with `pred_miss`=0. The wide packet `wid_pkt` is {tag in bits [71:64], value in bits [63:0]}.
- R9: A mispredict notice (`br_vld`) gives, one cycle later, `nar_vld`=1, `nar_is_br`=1, and `nar_pkt` holding the branch identifier in bits [7:0] with zeros above.
- R10: When a notice and a narrow, correctly predicted result arrive in the same cycle, the notice takes the narrow link. The result goes out whole on the wide link in that same cycle, and `pred_miss` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_vld | input | 1 | Dispatch lookup request |
| disp_pc | input | 32 | Instruction address of the lookup |
| disp_rsp_vld | output | 1 | Lookup answer valid (one cycle after request) |
| disp_rsp_nar | output | 1 | Lookup answer: result expected narrow |
| wb_vld | input | 1 | Writeback result valid |
| wb_pc | input | 32 | Instruction address of the result |
| wb_tag | input | 8 | Destination register tag |
| wb_val | input | 64 | Result value |
| wb_pred_nar | input | 1 | Prediction made for this result at dispatch |
| br_vld | input | 1 | Branch-mispredict notice valid |
| br_id | input | 8 | Branch identifier |
| nar_vld | output | 1 | Narrow link packet valid |
| nar_is_br | output | 1 | Narrow packet is a mispredict notice |
| nar_pkt | output | 18 | Narrow link packet |
| wid_vld | output | 1 | Wide link packet valid |
| wid_pkt | output | 72 | Wide link packet |
| pred_miss | output | 1 | Result predicted narrow was wide; replay wake-up |

## Verification
A corrupted counter shows up only through the lookup port. It appears as a wrong `disp_rsp_nar` on the first lookup of that address, which is one cycle after the request and no earlier than one cycle after the training write. The bench therefore walks counters through each value and reads them back after every write. A wrong saturation bound stays hidden until a run of three or more like results, so the bench drives runs past both ends. Steering faults appear one cycle after the writeback: a packet on the wrong link, a swapped tag or data field, or a missing or extra `pred_miss` pulse.

// File: rtl/nrw_steer_pkg.sv
package nrw_steer_pkg;
   localparam int unsigned NRW_TAG_W   = 8;
   localparam int unsigned NRW_NDATA_W = 10;
   localparam int unsigned NRW_DATA_W  = 64;
   localparam int unsigned NRW_CTR_W   = 2;

   // link selection for one writeback
   typedef enum logic [1:0] {
      LNK_NONE = 2'd0,
      LNK_NAR  = 2'd1,
      LNK_WID  = 2'd2
   } lnk_sel_e;
endpackage

// File: rtl/nrw_pred_table.sv
module nrw_pred_table #(
   parameter int unsigned IDX_W = 13,
   parameter int unsigned CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_vld,
   output logic             rd_conf,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
   localparam logic [CTR_W-1:0] CTR_MIN = '0;

   generate
      if (CTR_W < 1 || CTR_W > 4) begin : g_bad_ctr
         $error("nrw_pred_table: CTR_W must be 1..4");
      end
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("nrw_pred_table: IDX_W must be 1..16");
      end
   endgenerate

   logic [CTR_W-1:0] ctr_q [DEPTH];
   logic [CTR_W-1:0] wr_old;
   logic [CTR_W-1:0] wr_new;

   assign wr_old = ctr_q[wr_idx];

   always_comb begin
      wr_new = wr_old;
      if (wr_up) begin
         if (wr_old != CTR_MAX) wr_new = wr_old + 1'b1;
      end else begin
         if (wr_old != CTR_MIN) wr_new = wr_old - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_MIN;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= wr_new;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld  <= 1'b0;
         rd_conf <= 1'b0;
      end else begin
         rd_vld  <= rd_en;
         rd_conf <= rd_en && (ctr_q[rd_idx] == CTR_MAX);
      end
   end
endmodule

// File: rtl/nrw_width_detect.sv
module nrw_width_detect #(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned NDATA_W = 10
) (
   input  logic [DATA_W-1:0] val,
   output logic              is_nar
);
   generate
      if (NDATA_W > DATA_W) begin : g_bad
         $error("nrw_width_detect: NDATA_W exceeds DATA_W");
      end else if (NDATA_W == DATA_W) begin : g_all_nar
         assign is_nar = 1'b1;
      end else begin : g_cmp
         assign is_nar = ~|val[DATA_W-1:NDATA_W];
      end
   endgenerate
endmodule

// File: rtl/nrw_chan_pack.sv
module nrw_chan_pack
   import nrw_steer_pkg::*;
#(
   parameter int unsigned TAG_W   = 8,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned NDATA_W = 10,
   parameter int unsigned BRID_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wb_vld,
   input  logic [TAG_W-1:0]          wb_tag,
   input  logic [DATA_W-1:0]         wb_val,
   input  logic                      wb_pred_nar,
   input  logic                      wb_is_nar,
   input  logic                      br_vld,
   input  logic [BRID_W-1:0]         br_id,
   output logic                      nar_vld,
   output logic                      nar_is_br,
   output logic [TAG_W+NDATA_W-1:0]  nar_pkt,
   output logic                      wid_vld,
   output logic [TAG_W+DATA_W-1:0]   wid_pkt,
   output logic                      pred_miss
);
   localparam int unsigned NLINK_W = TAG_W + NDATA_W;
   localparam int unsigned WLINK_W = TAG_W + DATA_W;
   localparam int unsigned PAD_W   = NLINK_W - BRID_W;

   generate
      if (BRID_W >= NLINK_W) begin : g_bad_brid
         $error("nrw_chan_pack: BRID_W must be narrower than the narrow link");
      end
   endgenerate

   lnk_sel_e               sel;
   logic                   nar_d_vld;
   logic [NLINK_W-1:0]     nar_d_pkt;
   logic [WLINK_W-1:0]     wid_d_pkt;
   logic                   miss_d;

   always_comb begin
      sel = LNK_NONE;
      if (wb_vld) begin
         if (wb_pred_nar && wb_is_nar && !br_vld) sel = LNK_NAR;
         else                                     sel = LNK_WID;
      end
      nar_d_vld = br_vld || (sel == LNK_NAR);
      if (br_vld)              nar_d_pkt = {{PAD_W{1'b0}}, br_id};
      else if (sel == LNK_NAR) nar_d_pkt = {wb_tag, wb_val[NDATA_W-1:0]};
      else                     nar_d_pkt = '0;
      wid_d_pkt = (sel == LNK_WID) ? {wb_tag, wb_val} : '0;
      miss_d    = wb_vld && wb_pred_nar && !wb_is_nar;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nar_vld   <= 1'b0;
         nar_is_br <= 1'b0;
         nar_pkt   <= '0;
         wid_vld   <= 1'b0;
         wid_pkt   <= '0;
         pred_miss <= 1'b0;
      end else begin
         nar_vld   <= nar_d_vld;
         nar_is_br <= br_vld;
         nar_pkt   <= nar_d_pkt;
         wid_vld   <= (sel == LNK_WID);
         wid_pkt   <= wid_d_pkt;
         pred_miss <= miss_d;
      end
   end
endmodule

// File: rtl/opnd_width_steer.sv
module opnd_width_steer
   import nrw_steer_pkg::*;
#(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned IDX_LO  = 2,
   parameter int unsigned IDX_W   = 13,
   parameter int unsigned CTR_W   = NRW_CTR_W,
   parameter int unsigned TAG_W   = NRW_TAG_W,
   parameter int unsigned DATA_W  = NRW_DATA_W,
   parameter int unsigned NDATA_W = NRW_NDATA_W,
   parameter int unsigned BRID_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     disp_vld,
   input  logic [PC_W-1:0]          disp_pc,
   output logic                     disp_rsp_vld,
   output logic                     disp_rsp_nar,
   input  logic                     wb_vld,
   input  logic [PC_W-1:0]          wb_pc,
   input  logic [TAG_W-1:0]         wb_tag,
   input  logic [DATA_W-1:0]        wb_val,
   input  logic                     wb_pred_nar,
   input  logic                     br_vld,
   input  logic [BRID_W-1:0]        br_id,
   output logic                     nar_vld,
   output logic                     nar_is_br,
   output logic [TAG_W+NDATA_W-1:0] nar_pkt,
   output logic                     wid_vld,
   output logic [TAG_W+DATA_W-1:0]  wid_pkt,
   output logic                     pred_miss
);
   localparam int unsigned IDX_HI = IDX_LO + IDX_W - 1;

   generate
      if (IDX_HI >= PC_W) begin : g_bad_pc
         $error("opnd_width_steer: index field exceeds PC width");
      end
   endgenerate

   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] wr_idx;
   logic             wb_is_nar;

   assign rd_idx = disp_pc[IDX_HI:IDX_LO];
   assign wr_idx = wb_pc[IDX_HI:IDX_LO];

   nrw_pred_table #(
      .IDX_W (IDX_W),
      .CTR_W (CTR_W)
   ) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (disp_vld),
      .rd_idx  (rd_idx),
      .rd_vld  (disp_rsp_vld),
      .rd_conf (disp_rsp_nar),
      .wr_en   (wb_vld),
      .wr_idx  (wr_idx),
      .wr_up   (wb_is_nar)
   );

   nrw_width_detect #(
      .DATA_W  (DATA_W),
      .NDATA_W (NDATA_W)
   ) u_det (
      .val    (wb_val),
      .is_nar (wb_is_nar)
   );

   nrw_chan_pack #(
      .TAG_W   (TAG_W),
      .DATA_W  (DATA_W),
      .NDATA_W (NDATA_W),
      .BRID_W  (BRID_W)
   ) u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .wb_vld      (wb_vld),
      .wb_tag      (wb_tag),
      .wb_val      (wb_val),
      .wb_pred_nar (wb_pred_nar),
      .wb_is_nar   (wb_is_nar),
      .br_vld      (br_vld),
      .br_id       (br_id),
      .nar_vld     (nar_vld),
      .nar_is_br   (nar_is_br),
      .nar_pkt     (nar_pkt),
      .wid_vld     (wid_vld),
      .wid_pkt     (wid_pkt),
      .pred_miss   (pred_miss)
   );
endmodule

// File: rtl/nrw_steer_chk.sv
module nrw_steer_chk #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned TAG_W   = 8,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned NDATA_W = 10,
   parameter int unsigned BRID_W  = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     disp_vld,
   input logic                     disp_rsp_vld,
   input logic                     wb_vld,
   input logic [DATA_W-1:0]        wb_val,
   input logic                     wb_pred_nar,
   input logic                     br_vld,
   input logic                     nar_vld,
   input logic                     nar_is_br,
   input logic                     wid_vld,
   input logic                     pred_miss
);
   logic val_fits;
   assign val_fits = (wb_val >> NDATA_W) == '0;

   // R3
   lookup_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_vld |=> disp_rsp_vld);

   // R6
   nar_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_vld && wb_pred_nar && val_fits && !br_vld) |=>
         (nar_vld && !nar_is_br && !wid_vld && !pred_miss));

   // R7
   miss_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_miss |-> (wid_vld && !nar_vld));

   // R7
   miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_vld && wb_pred_nar && !val_fits) |=> pred_miss);

   // R8
   wide_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_vld && !wb_pred_nar) |=> (wid_vld && !pred_miss));

   // R9
   brnote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_vld |=> (nar_vld && nar_is_br));

   // R10
   br_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_vld && wb_vld) |=> wid_vld);
endmodule

bind opnd_width_steer nrw_steer_chk #(
   .PC_W    (PC_W),
   .TAG_W   (TAG_W),
   .DATA_W  (DATA_W),
   .NDATA_W (NDATA_W),
   .BRID_W  (BRID_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .disp_vld     (disp_vld),
   .disp_rsp_vld (disp_rsp_vld),
   .wb_vld       (wb_vld),
   .wb_val       (wb_val),
   .wb_pred_nar  (wb_pred_nar),
   .br_vld       (br_vld),
   .nar_vld      (nar_vld),
   .nar_is_br    (nar_is_br),
   .wid_vld      (wid_vld),
   .pred_miss    (pred_miss)
);

// File: tb/opnd_width_steer_test.sv
module opnd_width_steer_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        disp_vld;
   logic [31:0] disp_pc;
   logic        disp_rsp_vld;
   logic        disp_rsp_nar;
   logic        wb_vld;
   logic [31:0] wb_pc;
   logic [7:0]  wb_tag;
   logic [63:0] wb_val;
   logic        wb_pred_nar;
   logic        br_vld;
   logic [7:0]  br_id;
   logic        nar_vld;
   logic        nar_is_br;
   logic [17:0] nar_pkt;
   logic        wid_vld;
   logic [71:0] wid_pkt;
   logic        pred_miss;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opnd_width_steer uut (
      .clk(clk), .rst_n(rst_n),
      .disp_vld(disp_vld), .disp_pc(disp_pc),
      .disp_rsp_vld(disp_rsp_vld), .disp_rsp_nar(disp_rsp_nar),
      .wb_vld(wb_vld), .wb_pc(wb_pc), .wb_tag(wb_tag), .wb_val(wb_val),
      .wb_pred_nar(wb_pred_nar), .br_vld(br_vld), .br_id(br_id),
      .nar_vld(nar_vld), .nar_is_br(nar_is_br), .nar_pkt(nar_pkt),
      .wid_vld(wid_vld), .wid_pkt(wid_pkt), .pred_miss(pred_miss)
   );

   task automatic chk(input bit ok, input string req, input logic [71:0] act,
                      input logic [71:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one writeback; returns at the negedge where its packet is visible
   task automatic do_wb(input logic [31:0] pc, input logic [7:0] tag,
                        input logic [63:0] val, input bit pn, input bit br,
                        input logic [7:0] id);
      @(negedge clk);
      wb_vld = 1'b1; wb_pc = pc; wb_tag = tag; wb_val = val; wb_pred_nar = pn;
      br_vld = br; br_id = id;
      @(negedge clk);
      wb_vld = 1'b0; br_vld = 1'b0;
   endtask

   task automatic look(input logic [31:0] pc, input bit exp_nar, input string req);
      @(negedge clk);
      disp_vld = 1'b1; disp_pc = pc;
      @(negedge clk);
      disp_vld = 1'b0;
      chk(disp_rsp_vld === 1'b1, req, disp_rsp_vld, 1);
      chk(disp_rsp_nar === exp_nar, req, disp_rsp_nar, exp_nar);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; disp_vld = 0; disp_pc = 0; wb_vld = 0; wb_pc = 0;
      wb_tag = 0; wb_val = 0; wb_pred_nar = 0; br_vld = 0; br_id = 0;
      repeat (3) @(negedge clk);
      chk({nar_vld, wid_vld, pred_miss, disp_rsp_vld} === 4'b0, "R1 idle in reset",
          {nar_vld, wid_vld, pred_miss, disp_rsp_vld}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({nar_vld, wid_vld, pred_miss, disp_rsp_vld} === 4'b0, "R1 idle after reset",
          {nar_vld, wid_vld, pred_miss, disp_rsp_vld}, 0);
      look(32'h0000_1230, 1'b0, "R1 untrained lookup wide");
   endtask

   // R5: needs three narrow results to reach confidence
   task automatic t_train_up();
      do_wb(32'h100, 8'h01, 64'd7, 0, 0, 0);
      look(32'h100, 1'b0, "R5 counter 1 wide");
      do_wb(32'h100, 8'h01, 64'd7, 0, 0, 0);
      look(32'h100, 1'b0, "R3 counter 2 wide");
      do_wb(32'h100, 8'h01, 64'd7, 0, 0, 0);
      look(32'h100, 1'b1, "R3 counter 3 narrow");
   endtask

   task automatic t_saturate();
      for (int i = 0; i < 3; i++) do_wb(32'h100, 8'h02, 64'd1, 0, 0, 0);
      do_wb(32'h100, 8'h02, 64'd5000, 0, 0, 0);
      look(32'h100, 1'b0, "R5 upper saturation then one decrement");
      do_wb(32'h100, 8'h02, 64'd0, 0, 0, 0);
      look(32'h100, 1'b1, "R5 back to full confidence");
      for (int i = 0; i < 6; i++) do_wb(32'h200, 8'h03, 64'hFFFF_0000_0000_0000, 0, 0, 0);
      for (int i = 0; i < 2; i++) do_wb(32'h200, 8'h03, 64'd3, 0, 0, 0);
      look(32'h200, 1'b0, "R5 lower saturation holds at 0");
      do_wb(32'h200, 8'h03, 64'd3, 0, 0, 0);
      look(32'h200, 1'b1, "R5 three increments from 0");
   endtask

   task automatic t_index();
      look(32'h103, 1'b1, "R4 low bits ignored");
      look(32'h0001_8100, 1'b1, "R4 bit 15 aliases");
      look(32'h104, 1'b0, "R4 bit 2 separates");
      look(32'h4100, 1'b0, "R4 bit 14 separates");
   endtask

   task automatic t_narrow_pkt();
      do_wb(32'h300, 8'hA5, 64'd1023, 1, 0, 0);
      chk(nar_vld && !nar_is_br && !wid_vld && !pred_miss, "R6 narrow link flags",
          {nar_vld, nar_is_br, wid_vld, pred_miss}, 4'b1000);
      chk(nar_pkt === {8'hA5, 10'h3FF}, "R6 narrow packet layout", nar_pkt, {8'hA5, 10'h3FF});
      do_wb(32'h300, 8'h5A, 64'd0, 1, 0, 0);
      chk(nar_pkt === {8'h5A, 10'h000} && nar_vld, "R2 zero is narrow", nar_pkt, {8'h5A, 10'h0});
   endtask

   task automatic t_miss();
      do_wb(32'h304, 8'h3C, 64'd1024, 1, 0, 0);
      chk(wid_vld && !nar_vld && pred_miss, "R7 1024 is wide, miss raised",
          {wid_vld, nar_vld, pred_miss}, 3'b101);
      chk(wid_pkt === {8'h3C, 64'd1024}, "R7 wide packet", wid_pkt, {8'h3C, 64'd1024});
      @(negedge clk);
      chk(pred_miss === 1'b0 && wid_vld === 1'b0, "R7 miss is one cycle", pred_miss, 0);
      do_wb(32'h308, 8'h11, 64'h8000_0000_0000_0001, 1, 0, 0);
      chk(pred_miss === 1'b1, "R2 top bit set is wide", pred_miss, 1);
   endtask

   task automatic t_wide_pred();
      do_wb(32'h30C, 8'hC3, 64'd5, 0, 0, 0);
      chk(wid_vld && !nar_vld && !pred_miss, "R8 predicted wide stays wide",
          {wid_vld, nar_vld, pred_miss}, 3'b100);
      chk(wid_pkt === {8'hC3, 64'd5}, "R8 wide packet layout", wid_pkt, {8'hC3, 64'd5});
   endtask

   task automatic t_branch();
      @(negedge clk);
      br_vld = 1'b1; br_id = 8'h9E;
      @(negedge clk);
      br_vld = 1'b0;
      chk(nar_vld && nar_is_br && !wid_vld, "R9 notice on narrow link",
          {nar_vld, nar_is_br, wid_vld}, 3'b110);
      chk(nar_pkt === 18'h0009E, "R9 notice packet", nar_pkt, 18'h0009E);
   endtask

   task automatic t_collide();
      do_wb(32'h310, 8'h77, 64'd300, 1, 1, 8'h42);
      chk(nar_vld && nar_is_br && nar_pkt === 18'h00042, "R10 notice wins narrow link",
          nar_pkt, 18'h00042);
      chk(wid_vld && wid_pkt === {8'h77, 64'd300} && !pred_miss, "R10 result moves to wide link",
          wid_pkt, {8'h77, 64'd300});
   endtask

   initial begin
      t_reset();
      t_train_up();
      t_saturate();
      t_index();
      t_narrow_pkt();
      t_miss();
      t_wide_pred();
      t_branch();
      t_collide();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule